// File: doc/BRIEF.md
# Delay Address Programming Interface

This block turns pin-level programming traffic into the 8-bit address that selects a tap of a programmable delay line. A mode pin picks between a parallel interface and a serial one. In parallel mode with the enable held high, the address tracks the eight parallel pins. When the enable is pulsed instead, the address takes the value those pins had when the enable fell. In serial mode a shift clock moves the serial input into an internal input register while the enable is high. The register's former contents leave on a serial output, so several units can be daisy-chained. The new address takes effect only when the enable falls.

Every pin is brought into the system clock domain through a synchronizer, and edges are found on the system clock. The system clock must therefore run several times faster than the shift clock and the enable. A single input register serves all three modes. A value written in parallel can be read back serially. A serial read empties the register, so the host must shift the read data back in if it wants to keep the setting. A one-cycle strobe marks every change of the address, so that the downstream delay line can switch taps at a known moment.

Top module: `dly_prog_if`

## Requirements
- R1: While reset is asserted, and on the cycle after it, the address is zero, the input register is zero, the serial output enable is low and the update strobe is low.
- R2: With mode=1 (parallel) and enable high, the address follows the parallel pins. A pin change reaches the address exactly three system clocks later: two synchronizer stages plus the address register.
- R3: With mode=1 and enable pulsed, the address takes the parallel value present when the enable fell. Parallel pin changes while the enable is low leave the address unchanged.
- R4: With mode=0 (serial) and enable high, each rising shift-clock edge moves the input register left by one bit and enters the serial input at bit 0, so the first bit sent ends in bit 7.
- R5: In serial mode the address stays unchanged while bits are shifted. It takes the input register's value when the enable falls.
- R6: The serial output always carries bit 7 of the input register. Shifting therefore sends out the old contents MSB first, and chained units programmed with 8·N bits each receive their own byte.
- R7: The parallel path and the serial path share one input register. A serial read returns the value last written by either path, and it replaces that value with the bits shifted in during the read.
- R8: The serial output enable is high only in serial mode while the enable is high. At all other times the serial output is treated as high-impedance.
- R9: In serial mode, shift-clock edges while the enable is low do not change the input register.
- R10: The update strobe is high for exactly one cycle, in the same cycle the address takes a new value. It stays low when a load leaves the address unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the shift clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 1 | 1 = parallel programming, 0 = serial programming |
| en_i | input | 1 | Address enable / load strobe |
| sclk_i | input | 1 | Serial shift clock |
| sdi_i | input | 1 | Serial data input |
| par_i | input | ADDR_W | Parallel address pins |
| sdo_o | output | 1 | Serial data output (bit 7 of the input register) |
| sdo_oe_o | output | 1 | Drive enable for the serial output; low means high-impedance |
| addr_o | output | ADDR_W | Active delay address |
| addr_upd_o | output | 1 | One-cycle strobe on each address change |

## Verification
The bench builds two copies of the block with the default 8-bit width and two synchronizer stages. The second copy takes its serial input from the first copy's serial output and shares the first copy's clock, enable and mode. With the two-stage default the three-cycle latency is known exactly, so the bench can sample the cycle before the address moves and the cycle after. The chained second copy exposes the 16-bit cascade order, and a parallel write followed by a serial read exposes the input register that both paths share.

// File: rtl/dpi_pkg.sv
package dpi_pkg;
  typedef enum logic {
    MODE_SERIAL   = 1'b0,
    MODE_PARALLEL = 1'b1
  } mode_e;

  localparam int CTL_W = 4;  // mode, enable, shift clock, serial data

  typedef struct packed {
    logic en_fall;
    logic sclk_rise;
  } edges_t;
endpackage

// File: rtl/dpi_sync.sv
module dpi_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  genvar g;
  for (g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[g] <= '0;
        else     stg[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[g] <= '0;
        else     stg[g] <= stg[g-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/dpi_edge.sv
module dpi_edge
  import dpi_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   en_s,
  input  logic   sclk_s,
  output edges_t edg
);
  logic en_q, sclk_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      sclk_q <= 1'b0;
    end else begin
      en_q   <= en_s;
      sclk_q <= sclk_s;
    end
  end

  assign edg.en_fall   = en_q & ~en_s;
  assign edg.sclk_rise = sclk_s & ~sclk_q;
endmodule

// File: rtl/dpi_inreg.sv
module dpi_inreg
  import dpi_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         mode_s,
  input  logic         en_s,
  input  logic         sclk_rise,
  input  logic         sdi_s,
  input  logic [W-1:0] par_s,
  output logic [W-1:0] ireg,
  output logic         sdo,
  output logic         sdo_oe
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ireg   <= '0;
      sdo_oe <= 1'b0;
    end else begin
      sdo_oe <= (mode_s == MODE_SERIAL) && en_s;
      if ((mode_s == MODE_PARALLEL) && en_s)
        ireg <= par_s;
      else if ((mode_s == MODE_SERIAL) && en_s && sclk_rise)
        ireg <= {ireg[W-2:0], sdi_s};
    end
  end

  assign sdo = ireg[W-1];
endmodule

// File: rtl/dpi_addr_latch.sv
module dpi_addr_latch
  import dpi_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         mode_s,
  input  logic         en_s,
  input  logic         en_fall,
  input  logic [W-1:0] par_s,
  input  logic [W-1:0] ireg,
  output logic [W-1:0] addr,
  output logic         upd
);
  logic [W-1:0] nxt;

  always_comb begin
    nxt = addr;
    if ((mode_s == MODE_PARALLEL) && en_s) nxt = par_s;
    else if (en_fall)                      nxt = ireg;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr <= '0;
      upd  <= 1'b0;
    end else begin
      upd  <= (nxt != addr);
      addr <= nxt;
    end
  end
endmodule

// File: rtl/dly_prog_if.sv
module dly_prog_if
  import dpi_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_i,
  input  logic              en_i,
  input  logic              sclk_i,
  input  logic              sdi_i,
  input  logic [ADDR_W-1:0] par_i,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              addr_upd_o
);
  localparam int SW = CTL_W + ADDR_W;

  logic [SW-1:0]     pins_s;
  logic              mode_s, en_s, sclk_s, sdi_s;
  logic [ADDR_W-1:0] par_s;
  logic [ADDR_W-1:0] ireg;
  edges_t            edg;
  logic              en_fall, sclk_rise;

  dpi_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({mode_i, en_i, sclk_i, sdi_i, par_i}),
    .q   (pins_s)
  );

  assign {mode_s, en_s, sclk_s, sdi_s, par_s} = pins_s;

  dpi_edge u_edge (
    .clk    (clk),
    .rst    (rst),
    .en_s   (en_s),
    .sclk_s (sclk_s),
    .edg    (edg)
  );

  assign en_fall   = edg.en_fall;
  assign sclk_rise = edg.sclk_rise;

  dpi_inreg #(.W(ADDR_W)) u_inreg (
    .clk       (clk),
    .rst       (rst),
    .mode_s    (mode_s),
    .en_s      (en_s),
    .sclk_rise (sclk_rise),
    .sdi_s     (sdi_s),
    .par_s     (par_s),
    .ireg      (ireg),
    .sdo       (sdo_o),
    .sdo_oe    (sdo_oe_o)
  );

  dpi_addr_latch #(.W(ADDR_W)) u_addr (
    .clk     (clk),
    .rst     (rst),
    .mode_s  (mode_s),
    .en_s    (en_s),
    .en_fall (en_fall),
    .par_s   (par_s),
    .ireg    (ireg),
    .addr    (addr_o),
    .upd     (addr_upd_o)
  );
endmodule

// File: rtl/dly_prog_if_chk.sv
module dly_prog_if_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         mode_s,
  input logic         en_s,
  input logic         en_fall,
  input logic         sclk_rise,
  input logic [W-1:0] ireg,
  input logic [W-1:0] addr_o,
  input logic         addr_upd_o,
  input logic         sdo_oe_o
);
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (addr_o == '0) && (ireg == '0) && !sdo_oe_o && !addr_upd_o);

  p_upd_on_change_r10: assert property (@(posedge clk) disable iff (rst)
    !$stable(addr_o) |-> addr_upd_o);

  p_upd_only_change_r10: assert property (@(posedge clk) disable iff (rst)
    addr_upd_o |-> !$stable(addr_o));

  p_oe_serial_only_r8: assert property (@(posedge clk) disable iff (rst)
    sdo_oe_o |-> $past(!mode_s && en_s));

  p_serial_hold_r5: assert property (@(posedge clk) disable iff (rst)
    ($past(!mode_s) && !$past(en_fall)) |-> $stable(addr_o));

  p_no_shift_r9: assert property (@(posedge clk) disable iff (rst)
    ($past(!mode_s) && !$past(sclk_rise && en_s)) |-> $stable(ireg));
endmodule

bind dly_prog_if dly_prog_if_chk #(.W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .mode_s     (mode_s),
  .en_s       (en_s),
  .en_fall    (en_fall),
  .sclk_rise  (sclk_rise),
  .ireg       (ireg),
  .addr_o     (addr_o),
  .addr_upd_o (addr_upd_o),
  .sdo_oe_o   (sdo_oe_o)
);

// File: tb/dly_prog_if_test.sv
module dly_prog_if_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       mode = 1'b1, en = 1'b0, sclk = 1'b0, sdi = 1'b0;
  logic [7:0] par = 8'h00;
  logic       sdo, sdo_oe, upd;
  logic [7:0] addr;
  logic       sdo2, sdo_oe2, upd2;
  logic [7:0] addr2;
  int checks = 0, fails = 0, upd_cnt = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dly_prog_if uut (
    .clk(clk), .rst(rst), .mode_i(mode), .en_i(en), .sclk_i(sclk),
    .sdi_i(sdi), .par_i(par), .sdo_o(sdo), .sdo_oe_o(sdo_oe),
    .addr_o(addr), .addr_upd_o(upd));

  dly_prog_if uut2 (
    .clk(clk), .rst(rst), .mode_i(mode), .en_i(en), .sclk_i(sclk),
    .sdi_i(sdo), .par_i(8'h00), .sdo_o(sdo2), .sdo_oe_o(sdo_oe2),
    .addr_o(addr2), .addr_upd_o(upd2));

  always @(posedge clk) if (!rst && upd) upd_cnt++;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic shift_bit(input logic b, output logic rd);
    rd = sdo;
    sdi = b;
    tick(3);
    sclk = 1'b1;
    tick(6);
    sclk = 1'b0;
    tick(4);
  endtask

  task automatic shift_byte(input logic [7:0] v, output logic [7:0] rd);
    for (int i = 7; i >= 0; i--) begin
      logic r;
      shift_bit(v[i], r);
      rd[i] = r;
    end
  endtask

  task automatic t_reset();
    check(addr == 8'h00, "R1 addr", addr, 8'h00);
    check(sdo_oe == 1'b0, "R1 oe", sdo_oe, 0);
    check(upd == 1'b0, "R1 upd", upd, 0);
    check(sdo == 1'b0, "R1 ireg msb", sdo, 0);
  endtask

  task automatic t_transparent();
    mode = 1'b1; en = 1'b1; par = 8'hA5;
    tick(2);
    check(addr == 8'h00, "R2 before latency", addr, 8'h00);
    tick(1);
    check(addr == 8'hA5, "R2 at latency", addr, 8'hA5);
    tick(4);
    upd_cnt = 0;
    par = 8'h3C;
    tick(8);
    check(addr == 8'h3C, "R2 follow", addr, 8'h3C);
    check(upd_cnt == 1, "R10 one strobe", upd_cnt, 1);
    check(sdo_oe == 1'b0, "R8 oe low in parallel", sdo_oe, 0);
    upd_cnt = 0;
    tick(8);
    check(upd_cnt == 0, "R10 no strobe when steady", upd_cnt, 0);
  endtask

  task automatic t_latched();
    en = 1'b0;
    tick(6);
    par = 8'h81;
    tick(8);
    check(addr == 8'h3C, "R3 ignore pins while enable low", addr, 8'h3C);
    en = 1'b1;
    tick(1);
    en = 1'b0;
    tick(1);
    par = 8'h22;
    tick(8);
    check(addr == 8'h81, "R3 capture at fall", addr, 8'h81);
  endtask

  task automatic t_serial_write();
    logic [7:0] rd;
    mode = 1'b0;
    tick(6);
    check(sdo_oe == 1'b0, "R8 oe low enable low", sdo_oe, 0);
    en = 1'b1;
    tick(5);
    check(sdo_oe == 1'b1, "R8 oe high", sdo_oe, 1);
    shift_byte(8'h6B, rd);
    check(addr == 8'h81, "R5 hold while shifting", addr, 8'h81);
    check(rd == 8'h81, "R7 parallel value read serially", rd, 8'h81);
    upd_cnt = 0;
    en = 1'b0;
    tick(6);
    check(addr == 8'h6B, "R4 R5 apply at fall", addr, 8'h6B);
    check(upd_cnt == 1, "R10 strobe on serial load", upd_cnt, 1);
    check(sdo_oe == 1'b0, "R8 oe released", sdo_oe, 0);
  endtask

  task automatic t_readback();
    logic [7:0] rd;
    en = 1'b1;
    tick(5);
    check(sdo == 1'b0, "R6 bit7 at enable rise", sdo, 0);
    shift_byte(8'hD2, rd);
    check(rd == 8'h6B, "R6 old contents MSB first", rd, 8'h6B);
    en = 1'b0;
    tick(6);
    check(addr == 8'hD2, "R7 destructive read", addr, 8'hD2);
    en = 1'b1;
    tick(5);
    for (int i = 7; i >= 0; i--) begin
      logic r;
      shift_bit(sdo, r);
      rd[i] = r;
    end
    check(rd == 8'hD2, "R7 read value", rd, 8'hD2);
    upd_cnt = 0;
    en = 1'b0;
    tick(6);
    check(addr == 8'hD2, "R7 write-back keeps setting", addr, 8'hD2);
    check(upd_cnt == 0, "R10 no strobe on same value", upd_cnt, 0);
  endtask

  task automatic t_ignore_sclk();
    logic [7:0] rd;
    sdi = 1'b1;
    for (int i = 0; i < 8; i++) begin
      sclk = 1'b1; tick(6); sclk = 1'b0; tick(6);
    end
    en = 1'b1;
    tick(5);
    for (int i = 7; i >= 0; i--) begin
      logic r;
      shift_bit(sdo, r);
      rd[i] = r;
    end
    en = 1'b0;
    tick(6);
    check(rd == 8'hD2, "R9 shift clock ignored with enable low", rd, 8'hD2);
  endtask

  task automatic t_cascade();
    logic [7:0] rd;
    en = 1'b1;
    tick(5);
    shift_byte(8'h3A, rd);
    shift_byte(8'hC7, rd);
    check(rd == 8'h3A, "R6 chained pass-through", rd, 8'h3A);
    en = 1'b0;
    tick(6);
    check(addr == 8'hC7, "R6 near unit byte", addr, 8'hC7);
    check(addr2 == 8'h3A, "R6 far unit byte", addr2, 8'h3A);
  endtask

  initial begin
    tick(4);
    t_reset();
    rst = 1'b0;
    tick(1);
    t_reset();
    t_transparent();
    t_latched();
    t_serial_write();
    t_readback();
    t_ignore_sclk();
    t_cascade();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule